// File: doc/BRIEF.md
# Static Memory Bus Controller

This block turns single-beat read and write requests from an on-chip master into asynchronous cycles on an external bus that serves up to four static devices. Each device sits in its own address region and has its own active-low chip select. It also has its own timing setup: the bus width (16 or 32 bits), the strobe style, the read protocol, the wait-state count and the data float time.

The internal side is a request/acknowledge port. The master holds `req_i` together with the address, write data, byte enables, direction and size until `ack_o` pulses. It then drops the request. The external side drives the address, the write data with a tristate enable, the chip selects, four byte strobes, an output enable and a write strobe. It samples an active-low wait input that can stretch the access. The per-region settings are static configuration inputs and change only while the bus is idle.

Top module: `smc_top`

## Requirements
- R1: Address bits [23:22] pick region r. During the active phase of an access, only `ebi_cs_no[r]` is low and `ebi_addr_o` carries the request address. At all other times every chip select is high.
- R2: An access to a disabled region, an access with size code 3, or a word access (size code 2) to a 16-bit region asserts no chip select. It acknowledges in the cycle after acceptance with `err_o`=1.
- R3: `ack_o` is high for exactly one cycle, in the cycle after the last active cycle, and `err_o` is 0 for a valid access. For a read in that cycle, `rdata_o` equals the bus data: all 32 bits on a 32-bit region, or the low 16 bits copied into both halves on a 16-bit region.
- R4: Without wait-input stretching, the active phase lasts 1 + ws cycles, where ws is the 3-bit wait-state setting of the region. A read using the delayed-output-enable protocol adds one cycle.
- R5: The access ends only at a clock edge where the wait counter has expired and `ebi_wait_ni` is high. While the input is low, the cycle is held with all strobes unchanged.
- R6: With `cs_oedly_i[r]`=0, a read drives `ebi_oe_no` low in every active cycle. With `cs_oedly_i[r]`=1, it stays high in the first active cycle and is low in the rest. Writes never assert `ebi_oe_no`.
- R7: With `cs_bsel_i[r]`=0 (byte-write mode), a write drives `ebi_bs_no` low on the enabled lanes for the whole active phase, and `ebi_we_no` stays high. A read in this mode keeps all of `ebi_bs_no` high.
- R8: With `cs_bsel_i[r]`=1 (byte-select mode), `ebi_bs_no` is low on the enabled lanes for the whole active phase of reads and writes. `ebi_we_no` is low for the whole active phase of a write.
- R9: On a 32-bit region, lane n follows `be_i[n]` and the bus carries `wdata_i`. On a 16-bit region, lanes 1:0 follow `be_i[3:2]` and bits 15:0 carry `wdata_i[31:16]` when address bit 1 is set, otherwise they take `be_i[1:0]` and `wdata_i[15:0]`. Lanes 3:2 stay high and bits 31:16 are 0.
- R10: After a read from region r with float setting F, a request to a different region is not accepted until F+1 idle cycles have followed the acknowledge cycle. A request to the same region waits only the normal single idle cycle.
- R11: `ebi_data_oe_o` is high only during the active phase of a write, and never while `ebi_oe_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_en_i | input | 4 | Region enable, one bit per region |
| cs_bw32_i | input | 4 | 1: 32-bit bus, 0: 16-bit bus |
| cs_bsel_i | input | 4 | 1: byte-select strobes, 0: byte-write strobes |
| cs_oedly_i | input | 4 | 1: output enable delayed one cycle after chip select |
| cs_ws_i | input | 12 | Wait states, 3 bits per region (region r at bits 3r+2:3r) |
| cs_tdf_i | input | 12 | Data float cycles, 3 bits per region (region r at bits 3r+2:3r) |
| req_i | input | 1 | Access request, held until acknowledge |
| we_i | input | 1 | 1: write, 0: read |
| addr_i | input | 24 | Byte address |
| size_i | input | 2 | 0 byte, 1 half-word, 2 word, 3 invalid |
| be_i | input | 4 | Byte enables on the 32-bit internal word |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with acknowledge |
| rdata_o | output | 32 | Read data, valid with acknowledge |
| ebi_addr_o | output | 24 | External address |
| ebi_data_o | output | 32 | External write data |
| ebi_data_oe_o | output | 1 | Drive enable for the external data bus |
| ebi_data_i | input | 32 | External read data |
| ebi_cs_no | output | 4 | Active-low chip selects |
| ebi_bs_no | output | 4 | Active-low byte write or byte select strobes |
| ebi_oe_no | output | 1 | Active-low output enable |
| ebi_we_no | output | 1 | Active-low write strobe |
| ebi_wait_ni | input | 1 | Active-low wait, extends the access |

## Verification
The assertions assume that the master holds its request stable until the acknowledge and drops it in the acknowledge cycle. They also assume that the configuration inputs do not move while an access or a float window is in progress. The stimulus drives every request from a task that changes inputs only on falling edges, drops the request as soon as the acknowledge is seen, and changes the region settings only between accesses after at least ten idle cycles. The wait input is pulled low only around an access, so the rule that a held cycle keeps its chip select is exercised both with and without expired wait states.

// File: rtl/smc_pkg.sv
`timescale 1ns/1ps
package smc_pkg;
  typedef enum logic [1:0] {S_IDLE, S_ACT, S_DONE} smc_state_e;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/smc_decode.sv
`timescale 1ns/1ps
module smc_decode import smc_pkg::*; #(
  parameter int N_CS  = 4,
  parameter int SEL_W = $clog2(N_CS)
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       size_i,
  input  logic [N_CS-1:0]  en_i,
  input  logic [N_CS-1:0]  bw32_i,
  output logic             err_o
);
  logic bad_size;
  always_comb begin
    bad_size = (size_i == 2'b11) || ((size_i == SZ_WORD) && !bw32_i[sel_i]);
    err_o    = !en_i[sel_i] || bad_size;
  end
endmodule

// File: rtl/smc_dncnt.sv
`timescale 1ns/1ps
module smc_dncnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= val_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/smc_lane.sv
`timescale 1ns/1ps
module smc_lane #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int HW    = DATA_W / 2,
  localparam int HB    = NB / 2
) (
  input  logic              wr_bw32_i,
  input  logic              hsel_i,
  input  logic [NB-1:0]     be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NB-1:0]     lanes_o,
  output logic [DATA_W-1:0] bus_wr_o,
  input  logic              rd_bw32_i,
  input  logic [DATA_W-1:0] bus_rd_i,
  output logic [DATA_W-1:0] rdata_o
);
  // Low half of the bus: direct on wide regions, half-word mux on narrow ones
  logic [HB-1:0] be_lo_n;
  logic [HW-1:0] wd_lo_n;
  assign be_lo_n = hsel_i ? be_i[NB-1:HB] : be_i[HB-1:0];
  assign wd_lo_n = hsel_i ? wdata_i[DATA_W-1:HW] : wdata_i[HW-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_half
    if (h == 0) begin : g_lo
      assign lanes_o[HB-1:0]  = wr_bw32_i ? be_i[HB-1:0] : be_lo_n;
      assign bus_wr_o[HW-1:0] = wr_bw32_i ? wdata_i[HW-1:0] : wd_lo_n;
      assign rdata_o[HW-1:0]  = bus_rd_i[HW-1:0];
    end else begin : g_hi
      assign lanes_o[NB-1:HB]      = wr_bw32_i ? be_i[NB-1:HB] : '0;
      assign bus_wr_o[DATA_W-1:HW] = wr_bw32_i ? wdata_i[DATA_W-1:HW] : '0;
      assign rdata_o[DATA_W-1:HW]  = rd_bw32_i ? bus_rd_i[DATA_W-1:HW] : bus_rd_i[HW-1:0];
    end
  end
endmodule

// File: rtl/smc_top.sv
`timescale 1ns/1ps
module smc_top import smc_pkg::*; #(
  parameter int N_CS   = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int WS_W   = 3,
  parameter int TDF_W  = 3,
  localparam int NB    = DATA_W / 8,
  localparam int SEL_W = $clog2(N_CS),
  localparam int CNT_W = WS_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CS-1:0]        cs_en_i,
  input  logic [N_CS-1:0]        cs_bw32_i,
  input  logic [N_CS-1:0]        cs_bsel_i,
  input  logic [N_CS-1:0]        cs_oedly_i,
  input  logic [N_CS*WS_W-1:0]   cs_ws_i,
  input  logic [N_CS*TDF_W-1:0]  cs_tdf_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [1:0]             size_i,
  input  logic [NB-1:0]          be_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic                   ack_o,
  output logic                   err_o,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [ADDR_W-1:0]      ebi_addr_o,
  output logic [DATA_W-1:0]      ebi_data_o,
  output logic                   ebi_data_oe_o,
  input  logic [DATA_W-1:0]      ebi_data_i,
  output logic [N_CS-1:0]        ebi_cs_no,
  output logic [NB-1:0]          ebi_bs_no,
  output logic                   ebi_oe_no,
  output logic                   ebi_we_no,
  input  logic                   ebi_wait_ni
);
  smc_state_e        state_q;
  logic [SEL_W-1:0]  cur_q, flt_cs_q, sel;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, bus_wr, rd_steer;
  logic [NB-1:0]     lanes_q, lanes_n;
  logic              we_q, first_q, ack_q, err_q;
  logic              dec_err, accept, act, act_done;
  logic              ws_zero, flt_zero, ws_load, flt_load;
  logic [CNT_W-1:0]  ws_val;
  logic [TDF_W-1:0]  flt_val;
  logic [WS_W-1:0]   ws_sel;
  logic [TDF_W-1:0]  tdf_cur;

  assign sel     = addr_i[ADDR_W-1 -: SEL_W];
  assign ws_sel  = cs_ws_i[sel*WS_W +: WS_W];
  assign tdf_cur = cs_tdf_i[cur_q*TDF_W +: TDF_W];
  assign act     = (state_q == S_ACT);

  smc_decode #(.N_CS(N_CS), .SEL_W(SEL_W)) i_decode (
    .sel_i  (sel),
    .size_i (size_i),
    .en_i   (cs_en_i),
    .bw32_i (cs_bw32_i),
    .err_o  (dec_err)
  );

  smc_lane #(.DATA_W(DATA_W)) i_lane (
    .wr_bw32_i (cs_bw32_i[sel]),
    .hsel_i    (addr_i[1]),
    .be_i      (be_i),
    .wdata_i   (wdata_i),
    .lanes_o   (lanes_n),
    .bus_wr_o  (bus_wr),
    .rd_bw32_i (cs_bw32_i[cur_q]),
    .bus_rd_i  (ebi_data_i),
    .rdata_o   (rd_steer)
  );

  // Other regions stay off the bus until the float window has drained
  assign accept   = (state_q == S_IDLE) && req_i &&
                    (dec_err || flt_zero || (sel == flt_cs_q));
  assign act_done = act && ws_zero && ebi_wait_ni;

  assign ws_load = accept && !dec_err;
  assign ws_val  = {1'b0, ws_sel} + {{WS_W{1'b0}}, (!we_i && cs_oedly_i[sel])};

  smc_dncnt #(.W(CNT_W)) i_ws_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ws_load),
    .val_i  (ws_val),
    .dec_i  (act),
    .zero_o (ws_zero)
  );

  assign flt_load = (accept && !dec_err) || (act_done && !we_q);
  assign flt_val  = act_done ? tdf_cur : '0;

  smc_dncnt #(.W(TDF_W)) i_flt_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (flt_load),
    .val_i  (flt_val),
    .dec_i  (state_q == S_IDLE),
    .zero_o (flt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cur_q    <= '0;
      flt_cs_q <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      lanes_q  <= '0;
      we_q     <= 1'b0;
      first_q  <= 1'b0;
      ack_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            if (dec_err) begin
              state_q <= S_DONE;
              ack_q   <= 1'b1;
              err_q   <= 1'b1;
            end else begin
              state_q <= S_ACT;
              cur_q   <= sel;
              addr_q  <= addr_i;
              wdata_q <= bus_wr;
              lanes_q <= lanes_n;
              we_q    <= we_i;
              first_q <= 1'b1;
            end
          end
        end
        S_ACT: begin
          first_q <= 1'b0;
          if (act_done) begin
            state_q <= S_DONE;
            ack_q   <= 1'b1;
            if (!we_q) begin
              rdata_q  <= rd_steer;
              flt_cs_q <= cur_q;
            end
          end
        end
        S_DONE: begin
          state_q <= S_IDLE;
          ack_q   <= 1'b0;
          err_q   <= 1'b0;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic [N_CS-1:0] cs_hot;
  always_comb begin
    cs_hot = '0;
    if (act) cs_hot[cur_q] = 1'b1;
  end

  assign ebi_cs_no     = ~cs_hot;
  assign ebi_addr_o    = addr_q;
  assign ebi_data_o    = wdata_q;
  assign ebi_data_oe_o = act && we_q;
  assign ebi_oe_no     = !(act && !we_q && (!cs_oedly_i[cur_q] || !first_q));
  assign ebi_we_no     = !(act && we_q && cs_bsel_i[cur_q]);
  assign ebi_bs_no     = (act && (cs_bsel_i[cur_q] || we_q)) ? ~lanes_q : '1;
  assign ack_o         = ack_q;
  assign err_o         = err_q;
  assign rdata_o       = rdata_q;
endmodule

// File: rtl/smc_chk.sv
`timescale 1ns/1ps
module smc_chk #(
  parameter int N_CS = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ack_o,
  input logic            err_o,
  input logic [N_CS-1:0] ebi_cs_no,
  input logic            ebi_oe_no,
  input logic            ebi_we_no,
  input logic            ebi_data_oe_o,
  input logic            ebi_wait_ni
);
  // R1
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ebi_cs_no));
  // R3
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R2
  err_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ack_o);
  // R2
  err_no_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && err_o) |-> $past(&ebi_cs_no));
  // R5
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&ebi_cs_no) && !ebi_wait_ni) |=> $stable(ebi_cs_no));
  // R6
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ebi_oe_no && !ebi_we_no));
  // R11
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ebi_data_oe_o |-> ebi_oe_no);
endmodule

bind smc_top smc_chk #(.N_CS(N_CS)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ack_o         (ack_o),
  .err_o         (err_o),
  .ebi_cs_no     (ebi_cs_no),
  .ebi_oe_no     (ebi_oe_no),
  .ebi_we_no     (ebi_we_no),
  .ebi_data_oe_o (ebi_data_oe_o),
  .ebi_wait_ni   (ebi_wait_ni)
);

// File: tb/test_smc_top.sv
`timescale 1ns/1ps
module test_smc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cs_en, cs_bw32, cs_bsel, cs_oedly;
  logic [11:0] cs_ws, cs_tdf;
  logic        req = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [1:0]  size = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        ack, err;
  logic [31:0] rdata, bus_o, bus_i;
  logic [23:0] bus_a;
  logic        bus_oe, oe_n, we_n, wait_n = 1'b1;
  logic [3:0]  cs_n, bs_n;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  // External memory: read data is a fixed function of the address
  function automatic logic [31:0] mem_of(input logic [23:0] a);
    return {a[15:0] ^ 16'h5a5a, ~a[15:0]};
  endfunction
  assign bus_i = mem_of(bus_a);

  smc_top i_smc_top (
    .clk_i(clk), .rst_ni(rst_n),
    .cs_en_i(cs_en), .cs_bw32_i(cs_bw32), .cs_bsel_i(cs_bsel), .cs_oedly_i(cs_oedly),
    .cs_ws_i(cs_ws), .cs_tdf_i(cs_tdf),
    .req_i(req), .we_i(we), .addr_i(addr), .size_i(size), .be_i(be), .wdata_i(wdata),
    .ack_o(ack), .err_o(err), .rdata_o(rdata),
    .ebi_addr_o(bus_a), .ebi_data_o(bus_o), .ebi_data_oe_o(bus_oe), .ebi_data_i(bus_i),
    .ebi_cs_no(cs_n), .ebi_bs_no(bs_n), .ebi_oe_no(oe_n), .ebi_we_no(we_n),
    .ebi_wait_ni(wait_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access, checked cycle by cycle against the timing rules
  task automatic access(input logic w, input logic [23:0] a, input logic [1:0] sz,
                        input logic [3:0] b, input logic [31:0] wd, input int wj,
                        input int exp_stall, input bit now, input bit exp_err, input string tag);
    int r, ws, n, base, stall;
    bit dly, w32, bsl;
    logic [3:0] ln, ebs;
    logic [31:0] edat, erd;
    r    = int'(a[23:22]);
    ws   = int'(cs_ws[r*3 +: 3]);
    dly  = !w && cs_oedly[r];
    w32  = cs_bw32[r];
    bsl  = cs_bsel[r];
    base = ws + int'(dly) + 1;
    n    = (wj + 1 > base) ? wj + 1 : base;
    if (w32) begin
      ln = b; edat = wd;
    end else begin
      ln = {2'b00, a[1] ? b[3:2] : b[1:0]};
      edat = {16'h0, a[1] ? wd[31:16] : wd[15:0]};
    end
    ebs = (bsl || w) ? ~ln : 4'hf;
    erd = w32 ? mem_of(a) : {mem_of(a)[15:0], mem_of(a)[15:0]};
    if (!now) repeat (10) @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; be = b; wdata = wd;
    wait_n = (wj > 0) ? 1'b0 : 1'b1;
    stall = 0;
    @(negedge clk);
    while (&cs_n && !ack && stall < 30) begin
      stall++;
      @(negedge clk);
    end
    chk(stall == exp_stall, now ? "R10 start delay" : "R1 start delay", stall, exp_stall);
    if (exp_err) begin
      chk(ack && err, "R2 error ack", {ack, err}, 2'b11);
      chk(cs_n == 4'hf, "R2 no chip select", cs_n, 4'hf);
      req = 1'b0;
      return;
    end
    for (int i = 0; i <= n; i++) begin
      if (i < n) begin
        chk(cs_n == ~(4'b1 << r), "R1 chip select", cs_n, ~(4'b1 << r));
        chk(bus_a == a, "R1 address", bus_a, a);
        chk(ack == 1'b0, {tag, " early ack"}, ack, 0);
        chk(oe_n == !(!w && (!cs_oedly[r] || i > 0)), "R6 output enable", oe_n,
            !(!w && (!cs_oedly[r] || i > 0)));
        chk(we_n == !(w && bsl), bsl ? "R8 write strobe" : "R7 write strobe", we_n, !(w && bsl));
        chk(bs_n == ebs, bsl ? "R8 byte strobes" : "R7 byte strobes", bs_n, ebs);
        chk(bus_oe == w, "R11 drive enable", bus_oe, w);
        if (w) chk(bus_o == edat, w32 ? "R9 wide data" : "R9 narrow data", bus_o, edat);
      end else begin
        chk(ack && !err, {tag, " ack cycle"}, {ack, err}, 2'b10);
        chk(cs_n == 4'hf, "R1 release", cs_n, 4'hf);
        if (!w) chk(rdata == erd, "R3 read data", rdata, erd);
      end
      if (i == wj) wait_n = 1'b1;
      if (i < n) @(negedge clk);
    end
    req = 1'b0;
    wait_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // region0: 32b byte-write, full OE, ws2, tdf3; region1: 16b byte-select, delayed OE, ws0
    // region2: 32b byte-select, delayed OE, ws5, tdf1; region3 disabled
    cs_en = 4'b0111; cs_bw32 = 4'b0101; cs_bsel = 4'b0110; cs_oedly = 4'b0110;
    cs_ws  = {3'd0, 3'd5, 3'd0, 3'd2};
    cs_tdf = {3'd0, 3'd1, 3'd0, 3'd3};
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hf && oe_n && we_n && bs_n == 4'hf, "R1 reset strobes",
        {cs_n, bs_n, oe_n, we_n}, 10'h3ff);
    chk(ack == 1'b0 && bus_oe == 1'b0, "R11 reset idle", {ack, bus_oe}, 0);
    rst_n = 1'b1;

    access(1, 24'h000104, 2'd2, 4'hf, 32'hdeadbeef, 0, 0, 0, 0, "R4");
    access(0, 24'h000208, 2'd2, 4'hf, 32'h0, 0, 0, 0, 0, "R4");
    access(1, 24'h000010, 2'd0, 4'b0100, 32'h00ab0000, 0, 0, 0, 0, "R7");
    access(1, 24'h400006, 2'd1, 4'b1100, 32'h1234abcd, 0, 0, 0, 0, "R9");
    access(1, 24'h400004, 2'd1, 4'b0011, 32'h1234abcd, 0, 0, 0, 0, "R9");
    access(0, 24'h400022, 2'd1, 4'b1100, 32'h0, 0, 0, 0, 0, "R6");
    access(0, 24'h800040, 2'd2, 4'hf, 32'h0, 9, 0, 0, 0, "R5");
    access(1, 24'h800044, 2'd1, 4'b0011, 32'h00005555, 2, 0, 0, 0, "R5");
    access(0, 24'hc00000, 2'd2, 4'hf, 32'h0, 0, 0, 0, 1, "R2");
    access(0, 24'h400000, 2'd2, 4'hf, 32'h0, 0, 0, 0, 1, "R2");
    access(0, 24'h000000, 2'd3, 4'hf, 32'h0, 0, 0, 0, 1, "R2");
    // float: read region0 (F=3), then region1 at once; then same region at once
    access(0, 24'h000300, 2'd2, 4'hf, 32'h0, 0, 0, 0, 0, "R4");
    access(0, 24'h400300, 2'd1, 4'b0011, 32'h0, 0, 4, 1, 0, "R10");
    access(0, 24'h000304, 2'd2, 4'hf, 32'h0, 0, 0, 0, 0, "R4");
    access(0, 24'h000308, 2'd2, 4'hf, 32'h0, 0, 1, 1, 0, "R10");
    // change region0 to zero wait states, region2 to the maximum
    repeat (10) @(negedge clk);
    cs_ws = {3'd0, 3'd7, 3'd0, 3'd0};
    access(0, 24'h000400, 2'd2, 4'hf, 32'h0, 0, 0, 0, 0, "R4");
    access(1, 24'h800400, 2'd0, 4'b1000, 32'h77000000, 0, 0, 0, 0, "R4");
    access(0, 24'h800404, 2'd2, 4'hf, 32'h0, 0, 0, 0, 0, "R4");
    repeat (10) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule